// File: doc/BRIEF.md
# Battery monitor register bank

This block is the byte-addressed register file of a current-measuring bus slave. It holds a control/status byte, a feature byte that drives a general-purpose open-drain pin, a read-only signed current word and a read/write accumulated-current word. Each 16-bit word appears to the bus front end as a high byte and a low byte at two adjacent addresses. The measurement path and the accumulation arithmetic sit outside the block. Their results arrive as 16-bit words, each with a one-cycle update strobe.

The bus front end issues single-cycle read and write strobes with an 8-bit address. It also raises a command-active flag for as long as one read-data command lasts. Reading the high byte of a word copies both bytes into a holding copy. Low-byte reads inside the same command then return that frozen copy, so the two bytes always belong to one sample. The register port is a plain strobe interface with no back-pressure: every access completes in one cycle, and read data is registered and valid on the cycle after the read strobe. Sleep entry and a long-low data-line event return the pin control to its released state. A sleep request is raised when sleeping is enabled and the long-low event occurs.

Top module: `bmon_regbank`

## Requirements
- R1: Read data appears on `rdata` one clock after `rd_en`. The control byte is at 01h: bit 6 enables sleep and bit 4 selects the alternate address opcode (driven on `opcode_alt_o`). Its other bits read as 0.
- R2: Any address other than 01h, 08h, 0Eh, 0Fh, 10h and 11h reads as 00h, and writes to it change no register.
- R3: The current word has its high byte at 0Eh and its low byte at 0Fh. It loads `cur_word` on `cur_upd` and ignores bus writes.
- R4: The accumulated word has its high byte at 10h and its low byte at 11h. A bus write replaces one byte. `acc_upd` loads the whole of `acc_word`.
- R5: A bus write to 10h or 11h in the same cycle as `acc_upd` wins. The update is discarded, the written byte takes the bus data, and the other byte keeps its old value.
- R6: A read of 0Eh or 10h captures both bytes of that word. Later reads of 0Fh or 11h return the captured low byte until `rd_cmd_active` is seen low. A new high-byte read captures again.
- R7: Writing 0 to bit 6 of the feature byte at 08h asserts `pin_pull_low`. Writing 1 releases the pin.
- R8: Reading 08h returns the level on `pin_sense` in bit 6, with all other bits 0.
- R9: Reset, `sleep_evt` and `dq_low_long` each set the pin control to released, whether or not sleep is enabled. Sleep events leave the control byte unchanged and win over a same-cycle write to 08h.
- R10: After reset the control byte reads 00h, `opcode_alt_o` and `sleep_req_o` are 0, and `pin_pull_low` is 0.
- R11: `sleep_req_o` is 1 in the cycle after `dq_low_long` when sleep is enabled. It is never 1 when sleep is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| rd_en | input | 1 | Byte read strobe |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rd_cmd_active | input | 1 | High while a read-data command is in progress |
| cur_word | input | 16 | Signed current measurement |
| cur_upd | input | 1 | Load strobe for the current word |
| acc_word | input | 16 | Accumulated-current result |
| acc_upd | input | 1 | Load strobe for the accumulated word |
| pin_sense | input | 1 | Sensed level of the general-purpose pin |
| pin_pull_low | output | 1 | Enable of the open-drain pull-low driver |
| sleep_evt | input | 1 | Device is entering sleep |
| dq_low_long | input | 1 | Data line has been low for the sleep time (2 s) |
| sleep_req_o | output | 1 | Request to enter sleep |
| opcode_alt_o | output | 1 | Alternate address-opcode select |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that a high-byte read happens only while `rd_cmd_active` is high. Both hold for a well-formed bus front end. The bench drives every access through tasks that raise exactly one strobe for one cycle. It keeps `rd_cmd_active` high around each read sequence and drops it only between commands. Event inputs and update strobes are one-cycle pulses applied on the falling edge.

// File: rtl/bmon_pkg.sv
package bmon_pkg;
  localparam int BYTE_W = 8;
  localparam int ADR_W  = 8;
  // register byte addresses
  localparam logic [ADR_W-1:0] A_CTRL   = 8'h01;
  localparam logic [ADR_W-1:0] A_FEAT   = 8'h08;
  localparam logic [ADR_W-1:0] A_CUR_HI = 8'h0E;
  localparam logic [ADR_W-1:0] A_CUR_LO = 8'h0F;
  localparam logic [ADR_W-1:0] A_ACC_HI = 8'h10;
  localparam logic [ADR_W-1:0] A_ACC_LO = 8'h11;
  // bit positions inside the byte registers
  localparam int B_SLEEP_EN = 6;
  localparam int B_OPC_ALT  = 4;
  localparam int B_PIN      = 6;
endpackage

// File: rtl/bmon_ctrl_regs.sv
module bmon_ctrl_regs
  import bmon_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_feat,
  input  logic [DW-1:0] wdata,
  input  logic          sleep_evt,
  input  logic          dq_low_long,
  output logic          sleep_en_q,
  output logic          opc_alt_q,
  output logic          pin_rel_q,
  output logic          sleep_req_q
);
  logic pin_force;
  assign pin_force = sleep_evt | dq_low_long;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_en_q  <= 1'b0;
      opc_alt_q   <= 1'b0;
      pin_rel_q   <= 1'b1;
      sleep_req_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sleep_en_q <= wdata[B_SLEEP_EN];
        opc_alt_q  <= wdata[B_OPC_ALT];
      end
      if (pin_force)    pin_rel_q <= 1'b1;
      else if (wr_feat) pin_rel_q <= wdata[B_PIN];
      sleep_req_q <= sleep_en_q & dq_low_long;
    end
  end
endmodule

// File: rtl/bmon_word_reg.sv
module bmon_word_reg
  import bmon_pkg::*;
#(
  parameter int DW       = BYTE_W,
  parameter bit WRITABLE = 1'b1,
  localparam int WW      = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [WW-1:0] upd_d,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [DW-1:0] wdata,
  input  logic          cap,
  input  logic          cmd_active,
  output logic [WW-1:0] live_q,
  output logic [WW-1:0] hold_q,
  output logic          held_q
);
  logic wr_hi_g, wr_lo_g;
  assign wr_hi_g = WRITABLE && wr_hi;
  assign wr_lo_g = WRITABLE && wr_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (wr_hi_g || wr_lo_g) begin
      if (wr_hi_g) live_q[WW-1:DW] <= wdata;
      if (wr_lo_g) live_q[DW-1:0]  <= wdata;
    end else if (upd) begin
      live_q <= upd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      held_q <= 1'b0;
    end else if (cap) begin
      hold_q <= live_q;
      held_q <= 1'b1;
    end else if (!cmd_active) begin
      held_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bmon_regbank.sv
module bmon_regbank
  import bmon_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int AW = ADR_W,
  localparam int WW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          rd_cmd_active,
  input  logic [WW-1:0] cur_word,
  input  logic          cur_upd,
  input  logic [WW-1:0] acc_word,
  input  logic          acc_upd,
  input  logic          pin_sense,
  output logic          pin_pull_low,
  input  logic          sleep_evt,
  input  logic          dq_low_long,
  output logic          sleep_req_o,
  output logic          opcode_alt_o
);
  logic sleep_en, opc_alt, pin_rel;
  logic [WW-1:0] cur_live, cur_hold, acc_live, acc_hold;
  logic cur_held, acc_held;
  logic [DW-1:0] rd_next;

  bmon_ctrl_regs #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_en && addr == A_CTRL),
    .wr_feat(wr_en && addr == A_FEAT),
    .wdata(wdata), .sleep_evt(sleep_evt), .dq_low_long(dq_low_long),
    .sleep_en_q(sleep_en), .opc_alt_q(opc_alt), .pin_rel_q(pin_rel),
    .sleep_req_q(sleep_req_o)
  );

  bmon_word_reg #(.DW(DW), .WRITABLE(1'b0)) u_cur (
    .clk(clk), .rst_n(rst_n), .upd(cur_upd), .upd_d(cur_word),
    .wr_hi(wr_en && addr == A_CUR_HI), .wr_lo(wr_en && addr == A_CUR_LO),
    .wdata(wdata), .cap(rd_en && addr == A_CUR_HI), .cmd_active(rd_cmd_active),
    .live_q(cur_live), .hold_q(cur_hold), .held_q(cur_held)
  );

  bmon_word_reg #(.DW(DW), .WRITABLE(1'b1)) u_acc (
    .clk(clk), .rst_n(rst_n), .upd(acc_upd), .upd_d(acc_word),
    .wr_hi(wr_en && addr == A_ACC_HI), .wr_lo(wr_en && addr == A_ACC_LO),
    .wdata(wdata), .cap(rd_en && addr == A_ACC_HI), .cmd_active(rd_cmd_active),
    .live_q(acc_live), .hold_q(acc_hold), .held_q(acc_held)
  );

  always_comb begin
    rd_next = '0;
    unique case (addr)
      A_CTRL: begin
        rd_next[B_SLEEP_EN] = sleep_en;
        rd_next[B_OPC_ALT]  = opc_alt;
      end
      A_FEAT:   rd_next[B_PIN] = pin_sense;
      A_CUR_HI: rd_next = cur_live[WW-1:DW];
      A_CUR_LO: rd_next = cur_held ? cur_hold[DW-1:0] : cur_live[DW-1:0];
      A_ACC_HI: rd_next = acc_live[WW-1:DW];
      A_ACC_LO: rd_next = acc_held ? acc_hold[DW-1:0] : acc_live[DW-1:0];
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  assign pin_pull_low = ~pin_rel;
  assign opcode_alt_o = opc_alt;
endmodule

// File: rtl/bmon_regbank_chk.sv
module bmon_regbank_chk
  import bmon_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic [7:0]  addr,
  input logic [7:0]  wdata,
  input logic [7:0]  rdata,
  input logic        rd_cmd_active,
  input logic        cur_upd,
  input logic        pin_pull_low,
  input logic        sleep_evt,
  input logic        dq_low_long,
  input logic        sleep_req_o,
  input logic        sleep_en,
  input logic [15:0] cur_live,
  input logic [15:0] acc_live,
  input logic [15:0] cur_hold,
  input logic        cur_held
);
  logic rsvd;
  assign rsvd = !(addr inside {A_CTRL, A_FEAT, A_CUR_HI, A_CUR_LO, A_ACC_HI, A_ACC_LO});

  // R2
  rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rsvd) |=> rdata == 8'h00);

  // R3
  cur_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_CUR_HI || addr == A_CUR_LO) && !cur_upd) |=> $stable(cur_live));

  // R5
  acc_wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ACC_HI) |=> acc_live[15:8] == $past(wdata));

  // R6
  cur_hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_held && rd_cmd_active && !(rd_en && addr == A_CUR_HI)) |=> $stable(cur_hold));

  // R9
  pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_evt || dq_low_long) |=> !pin_pull_low);

  // R11
  no_sleep_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_en) |=> !sleep_req_o);
endmodule

bind bmon_regbank bmon_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .rd_cmd_active(rd_cmd_active), .cur_upd(cur_upd),
  .pin_pull_low(pin_pull_low), .sleep_evt(sleep_evt), .dq_low_long(dq_low_long),
  .sleep_req_o(sleep_req_o), .sleep_en(sleep_en), .cur_live(cur_live),
  .acc_live(acc_live), .cur_hold(cur_hold), .cur_held(cur_held)
);

// File: tb/tb_bmon_regbank.sv
module tb_bmon_regbank;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 0, wr_en = 0, rd_cmd_active = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [15:0] cur_word = 0, acc_word = 0;
  logic cur_upd = 0, acc_upd = 0, pin_sense = 1'b1;
  logic pin_pull_low, sleep_evt = 0, dq_low_long = 0, sleep_req_o, opcode_alt_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bmon_regbank dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic end_cmd();
    @(negedge clk); rd_cmd_active = 0;
    @(negedge clk); rd_cmd_active = 1;
  endtask

  // {is_read, addr, data, expected}
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h01, 8'h00, 8'h00},  // R10 control resets to 0
    {1'b0, 8'h01, 8'hFF, 8'h00},
    {1'b1, 8'h01, 8'h00, 8'h50},  // R1 only bits 6 and 4
    {1'b0, 8'h01, 8'h00, 8'h00},
    {1'b1, 8'h01, 8'h00, 8'h00},  // R1
    {1'b0, 8'h05, 8'hAA, 8'h00},
    {1'b1, 8'h05, 8'h00, 8'h00},  // R2
    {1'b1, 8'hFF, 8'h00, 8'h00},  // R2
    {1'b0, 8'h10, 8'h12, 8'h00},
    {1'b0, 8'h11, 8'h34, 8'h00},
    {1'b1, 8'h10, 8'h00, 8'h12},  // R4
    {1'b1, 8'h11, 8'h00, 8'h34},  // R4
    {1'b0, 8'h0E, 8'h55, 8'h00},
    {1'b1, 8'h0E, 8'h00, 8'h00},  // R3 write ignored
    {1'b0, 8'h08, 8'hFF, 8'h00},
    {1'b1, 8'h08, 8'h00, 8'h40}   // R8 sense high
  };

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {15'd0, pin_pull_low}, 16'd0);
    chk("R10", {15'd0, opcode_alt_o}, 16'd0);
    chk("R10", {15'd0, sleep_req_o}, 16'd0);
    rst_n = 1; rd_cmd_active = 1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        rd(VEC[i][23:16], d);
        chk("R1/R2/R3/R4/R8 vector", {8'd0, d}, {8'd0, VEC[i][7:0]});
      end else begin
        wr(VEC[i][23:16], VEC[i][15:8]);
      end
    end
    end_cmd();

    // R3 update strobe
    @(negedge clk); cur_word = 16'h8123; cur_upd = 1;
    @(negedge clk); cur_upd = 0;
    rd(8'h0E, d); chk("R3", {8'd0, d}, 16'h0081);
    // R6 frozen low byte
    @(negedge clk); cur_word = 16'hF00F; cur_upd = 1;
    @(negedge clk); cur_upd = 0;
    rd(8'h0F, d); chk("R6", {8'd0, d}, 16'h0023);
    end_cmd();
    rd(8'h0F, d); chk("R6", {8'd0, d}, 16'h000F);
    rd(8'h0E, d); chk("R3", {8'd0, d}, 16'h00F0);
    end_cmd();

    // R5 write beats update
    @(negedge clk); wr_en = 1; addr = 8'h10; wdata = 8'h77; acc_word = 16'hABCD; acc_upd = 1;
    @(negedge clk); wr_en = 0; acc_upd = 0;
    rd(8'h10, d); chk("R5", {8'd0, d}, 16'h0077);
    rd(8'h11, d); chk("R5", {8'd0, d}, 16'h0034);
    end_cmd();
    @(negedge clk); acc_upd = 1;
    @(negedge clk); acc_upd = 0;
    rd(8'h10, d); chk("R4", {8'd0, d}, 16'h00AB);
    rd(8'h11, d); chk("R4", {8'd0, d}, 16'h00CD);
    end_cmd();

    // R7 / R8 pin control and sense
    wr(8'h08, 8'h00); chk("R7", {15'd0, pin_pull_low}, 16'd1);
    pin_sense = 0;
    rd(8'h08, d); chk("R8", {8'd0, d}, 16'h0000);
    pin_sense = 1;
    wr(8'h08, 8'h40); chk("R7", {15'd0, pin_pull_low}, 16'd0);

    // R9 release on sleep entry, and sleep event beats write
    wr(8'h08, 8'h00);
    @(negedge clk); sleep_evt = 1; wr_en = 1; addr = 8'h08; wdata = 8'h00;
    @(negedge clk); sleep_evt = 0; wr_en = 0;
    chk("R9", {15'd0, pin_pull_low}, 16'd0);
    // R9 / R11 long-low with sleep disabled
    wr(8'h08, 8'h00);
    @(negedge clk); dq_low_long = 1;
    @(negedge clk); dq_low_long = 0;
    chk("R9", {15'd0, pin_pull_low}, 16'd0);
    chk("R11", {15'd0, sleep_req_o}, 16'd0);
    // R11 sleep enabled
    wr(8'h01, 8'h50);
    chk("R1", {15'd0, opcode_alt_o}, 16'd1);
    @(negedge clk); dq_low_long = 1;
    @(negedge clk); dq_low_long = 0;
    chk("R11", {15'd0, sleep_req_o}, 16'd1);
    @(negedge clk);
    chk("R11", {15'd0, sleep_req_o}, 16'd0);
    rd(8'h01, d); chk("R9", {8'd0, d}, 16'h0050);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule